// File: doc/BRIEF.md
# Handle Hash Table Engine

This block keeps a table that maps a 32-bit object handle, issued under a 5-bit channel number, to a 32-bit context word. The table lives in a synchronous single-port RAM inside the block. Each slot takes two consecutive RAM words: the handle word at the even address and the context word at the odd address. Software-side logic sends one command at a time: insert, lookup or remove. The block turns the handle and channel into a home slot, walks the slots one by one with wraparound, and returns a status together with a context word.

The home slot comes from a hash. The handle is cut into chunks of `IDX_W` bits, starting at bit 0, and all the chunks are XORed together. The channel number, shifted left by `IDX_W-4`, is then XORed in, and the result is truncated to `IDX_W` bits. For an insert, the block packs the context word itself from the instance address, the engine selector and the channel. A slot is occupied when bit 31 of its context word is set. The block does not stop probing at an empty slot. A miss is reported only after every slot has been visited.

Each probe costs three cycles. The first reads the context word, the second reads the handle word, and the third makes the decision. An insert or remove that succeeds adds one cycle, because the second word has to be written. After reset the block writes zero to every RAM word before it accepts any command.

Top module: `hht_engine`

## Requirements
- R1: After reset, `cmd_ready` stays low while the block writes zero to all 2^(IDX_W+1) table words. It rises exactly 2^(IDX_W+1) clock edges after reset is released, and the table then holds no entries.
- R2: The home slot is the XOR of every `IDX_W`-bit chunk of the handle (least significant chunk first), XORed with the channel shifted left by `IDX_W-4`, truncated to `IDX_W` bits. Probing starts at this slot.
- R3: For an insert, the context word is built as follows: bits 15:0 are `cmd_inst`, bits 17:16 are `cmd_engine`, bits 28:24 are `cmd_chan`, bit 31 is 1, and all other bits are 0.
- R4: Insert (opcode 0) probes home, home+1, and onward, wrapping from slot 2^IDX_W-1 back to slot 0. It writes the handle and the packed context into the first slot whose context bit 31 is clear.
- R5: An insert that visits every slot without finding a free one returns status 1 (full), returns context 0, and leaves the table unchanged.
- R6: Lookup (opcode 1, and opcode 3 treated the same way) hits only on a slot whose context bit 31 is set and whose stored handle equals the request handle. A hit returns status 0 and the stored context word.
- R7: Remove (opcode 2) hits under the same rule as R6. It writes zero to both words of the slot and returns status 0 with the removed context word. The freed slot can be taken by a later insert.
- R8: A lookup or remove that visits every slot without a hit returns status 2 (not found) and context 0.
- R9: Commands use a valid/ready handshake. `cmd_ready` is low from the accepting edge until the response, and `rsp_valid` is a single-cycle pulse.
- R10: Counting clock edges after the accepting edge, the response appears after 3k edges for a lookup hit at the k-th probe, after 3k+1 edges for a successful insert or remove, and after 3*2^IDX_W edges for a full or not-found result.
- R11: A removed slot does not end a probe chain. Entries placed beyond it in the chain are still found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts the table clear |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_op | input | 2 | 0 insert, 1 lookup, 2 remove, 3 lookup |
| cmd_handle | input | 32 | Object handle |
| cmd_chan | input | 5 | Channel number |
| cmd_inst | input | 16 | Instance address in 16-byte units (used by insert) |
| cmd_engine | input | 2 | Engine selector (used by insert) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 ok, 1 table full, 2 not found |
| rsp_ctx | output | 32 | Context word on success, zero otherwise |

## Verification
The assertions assume that a command is offered only through the handshake, with its fields held stable while `cmd_valid` is high and `cmd_ready` is low. They also assume `rst_n` is held low for at least one edge before any command is offered. The stimulus raises `cmd_valid` only on a falling edge at which `cmd_ready` is already high, and drops it one step after the accepting edge. Random commands draw handles from a small pool with mixed channels, so that hash collisions, duplicate handles and removals in the middle of a chain occur naturally. Directed sequences then fill every slot, wrap past the last slot, and force the full and not-found outcomes.

// File: rtl/hht_pkg.sv
// Package: shared encodings for the handle hash table engine.
// Assumes a fixed 32-bit handle and context word; only the index width is tunable.
package hht_pkg;

    localparam int HANDLE_W = 32;
    localparam int WORD_W   = 32;
    localparam int CHAN_W   = 5;
    localparam int ENG_W    = 2;
    localparam int INST_W   = 16;
    localparam int VALID_BIT = 31;

    typedef enum logic [1:0] {
        OP_INSERT  = 2'd0,
        OP_LOOKUP  = 2'd1,
        OP_REMOVE  = 2'd2,
        OP_LOOKUP2 = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_FULL = 2'd1,
        ST_MISS = 2'd2
    } status_e;

    // Context word, most significant field first.
    typedef struct packed {
        logic              valid;
        logic [1:0]        pad_hi;
        logic [CHAN_W-1:0] chan;
        logic [5:0]        pad_mid;
        logic [ENG_W-1:0]  engine;
        logic [INST_W-1:0] inst;
    } ctx_t;

endpackage

// File: rtl/hht_hash.sv
// Module: hht_hash
// Computes the home slot: XOR of all IDX_W-bit chunks of the handle,
// XORed with the channel shifted left by IDX_W-4, truncated to IDX_W bits.
// Assumes IDX_W >= 4 so the channel shift is non-negative. Purely combinational.
module hht_hash #(
    parameter int IDX_W = 9
) (
    input  logic [hht_pkg::HANDLE_W-1:0] handle,
    input  logic [hht_pkg::CHAN_W-1:0]   chan,
    output logic [IDX_W-1:0]             slot
);
    localparam int NCHUNK = (hht_pkg::HANDLE_W + IDX_W - 1) / IDX_W;
    localparam int WIDE_W = IDX_W + hht_pkg::CHAN_W;

    logic [WIDE_W-1:0] chan_wide;
    logic [IDX_W-1:0]  fold;

    // Fold the handle chunk by chunk, starting at the least significant bits.
    always_comb begin
        fold = '0;
        for (int k = 0; k < NCHUNK; k++) begin
            fold = fold ^ IDX_W'(handle >> (k * IDX_W));
        end
    end

    // Move the channel to the top of the index and mix it in.
    always_comb begin
        chan_wide = WIDE_W'(chan) << (IDX_W - 4);
        slot      = fold ^ chan_wide[IDX_W-1:0];
    end

endmodule

// File: rtl/hht_ctx_pack.sv
// Module: hht_ctx_pack
// Builds the context word written on insert from its fields and sets the
// occupied flag. Combinational. Assumes the instance address is already
// expressed in 16-byte units.
module hht_ctx_pack (
    input  logic [hht_pkg::INST_W-1:0] inst,
    input  logic [hht_pkg::ENG_W-1:0]  engine,
    input  logic [hht_pkg::CHAN_W-1:0] chan,
    output hht_pkg::ctx_t              ctx
);
    // Place each field; reserved bits are zero.
    always_comb begin
        ctx         = '0;
        ctx.valid   = 1'b1;
        ctx.chan    = chan;
        ctx.engine  = engine;
        ctx.inst    = inst;
    end

endmodule

// File: rtl/hht_ram.sv
// Module: hht_ram
// Single-port synchronous RAM with one-cycle read latency. A write and a read
// of the same address in one cycle return the old data. No reset on the array:
// the engine clears it explicitly.
module hht_ram #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Registered read and write on the single port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end

endmodule

// File: rtl/hht_engine.sv
// Module: hht_engine (top)
// Handle hash table engine. Accepts one insert, lookup or remove command at a
// time, probes slots linearly from the hashed home slot with wraparound, and
// answers with a status and a context word. Each slot takes two RAM words:
// the handle word at the even address, the context word at the odd address.
// Assumes: a command is only presented through valid/ready, and reset is held
// low for at least one edge before use.
module hht_engine #(
    parameter int IDX_W = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [1:0]  cmd_op,
    input  logic [31:0] cmd_handle,
    input  logic [4:0]  cmd_chan,
    input  logic [15:0] cmd_inst,
    input  logic [1:0]  cmd_engine,
    output logic        rsp_valid,
    output logic [1:0]  rsp_status,
    output logic [31:0] rsp_ctx
);
    import hht_pkg::*;

    localparam int SLOTS   = 1 << IDX_W;
    localparam int WADDR_W = IDX_W + 1;
    localparam int WORDS   = 1 << WADDR_W;
    localparam int CNT_W   = IDX_W + 1;

    typedef enum logic [2:0] {
        S_CLEAR, S_IDLE, S_PCTX, S_PHND, S_CHECK, S_WR2
    } state_e;

    state_e              state;
    logic [WADDR_W-1:0]  clr_addr;
    op_e                 op_q;
    logic [WORD_W-1:0]   handle_q;
    ctx_t                newctx_q;
    logic [IDX_W-1:0]    start_q;
    logic [IDX_W-1:0]    slot_q;
    logic [WORD_W-1:0]   ctx_q;
    logic [CNT_W-1:0]    probe_cnt;
    logic                rsp_valid_q;
    logic [1:0]          rsp_status_q;
    logic [WORD_W-1:0]   rsp_ctx_q;

    logic [IDX_W-1:0]    home_slot;
    ctx_t                packed_ctx;

    logic                ram_we;
    logic [WADDR_W-1:0]  ram_addr;
    logic [WORD_W-1:0]   ram_wdata;
    logic [WORD_W-1:0]   ram_rdata;

    logic                is_ins;
    logic                is_rem;
    logic                slot_free;
    logic                slot_hit;
    logic                take;
    logic [IDX_W-1:0]    next_slot;
    logic                wrapped;

    hht_hash #(.IDX_W(IDX_W)) u_hash (
        .handle (cmd_handle),
        .chan   (cmd_chan),
        .slot   (home_slot)
    );

    hht_ctx_pack u_pack (
        .inst   (cmd_inst),
        .engine (cmd_engine),
        .chan   (cmd_chan),
        .ctx    (packed_ctx)
    );

    hht_ram #(.AW(WADDR_W), .DW(WORD_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    // Decode the slot under inspection in the decision cycle.
    always_comb begin
        is_ins    = (op_q == OP_INSERT);
        is_rem    = (op_q == OP_REMOVE);
        slot_free = !ctx_q[VALID_BIT];
        slot_hit  = ctx_q[VALID_BIT] && (ram_rdata == handle_q);
        take      = is_ins ? slot_free : slot_hit;
        next_slot = slot_q + 1'b1;
        wrapped   = (next_slot == start_q);
    end

    // Steer the single RAM port for clearing, probing and updating.
    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        unique case (state)
            S_CLEAR: begin
                ram_we   = 1'b1;
                ram_addr = clr_addr;
            end
            S_PCTX:  ram_addr = {slot_q, 1'b1};
            S_PHND:  ram_addr = {slot_q, 1'b0};
            S_CHECK: begin
                ram_addr = {slot_q, 1'b0};
                if (take && (is_ins || is_rem)) begin
                    ram_we    = 1'b1;
                    ram_wdata = is_ins ? handle_q : '0;
                end
            end
            S_WR2: begin
                ram_we    = 1'b1;
                ram_addr  = {slot_q, 1'b1};
                ram_wdata = is_ins ? WORD_W'(newctx_q) : '0;
            end
            default: ;
        endcase
    end

    // Control sequence: clear, accept, probe, decide, update, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_CLEAR;
            clr_addr     <= '0;
            op_q         <= OP_LOOKUP;
            handle_q     <= '0;
            newctx_q     <= '0;
            start_q      <= '0;
            slot_q       <= '0;
            ctx_q        <= '0;
            probe_cnt    <= '0;
            rsp_valid_q  <= 1'b0;
            rsp_status_q <= ST_OK;
            rsp_ctx_q    <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state)
                S_CLEAR: begin
                    clr_addr <= clr_addr + 1'b1;
                    if (clr_addr == WADDR_W'(WORDS - 1)) begin
                        state <= S_IDLE;
                    end
                end
                S_IDLE: begin
                    if (cmd_valid) begin
                        op_q      <= op_e'(cmd_op);
                        handle_q  <= cmd_handle;
                        newctx_q  <= packed_ctx;
                        start_q   <= home_slot;
                        slot_q    <= home_slot;
                        probe_cnt <= '0;
                        state     <= S_PCTX;
                    end
                end
                S_PCTX: state <= S_PHND;
                S_PHND: begin
                    ctx_q <= ram_rdata;
                    state <= S_CHECK;
                end
                S_CHECK: begin
                    probe_cnt <= probe_cnt + 1'b1;
                    if (take) begin
                        if (is_ins || is_rem) begin
                            state <= S_WR2;
                        end else begin
                            rsp_valid_q  <= 1'b1;
                            rsp_status_q <= ST_OK;
                            rsp_ctx_q    <= ctx_q;
                            state        <= S_IDLE;
                        end
                    end else if (wrapped) begin
                        rsp_valid_q  <= 1'b1;
                        rsp_status_q <= is_ins ? ST_FULL : ST_MISS;
                        rsp_ctx_q    <= '0;
                        state        <= S_IDLE;
                    end else begin
                        slot_q <= next_slot;
                        state  <= S_PCTX;
                    end
                end
                S_WR2: begin
                    rsp_valid_q  <= 1'b1;
                    rsp_status_q <= ST_OK;
                    rsp_ctx_q    <= is_ins ? WORD_W'(newctx_q) : ctx_q;
                    state        <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign cmd_ready  = (state == S_IDLE);
    assign rsp_valid  = rsp_valid_q;
    assign rsp_status = rsp_status_q;
    assign rsp_ctx    = rsp_ctx_q;

    // Guards on handshake, probing and results.
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                       // R9
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);                        // R9
    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'd3));                             // R8
    AST_FAIL_ZERO_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'd0) |-> (rsp_ctx == '0));          // R5
    AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd0) |-> rsp_ctx[VALID_BIT]);       // R6
    AST_INSERT_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR2 && op_q == OP_INSERT) |-> !ctx_q[VALID_BIT]);    // R4
    AST_PROBE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PCTX && $past(state) == S_CHECK)
            |-> (slot_q == $past(slot_q) + 1'b1));                       // R4
    AST_PROBE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        probe_cnt <= CNT_W'(SLOTS));                                     // R5

endmodule

// File: tb/hht_engine_tb.sv
// Testbench for hht_engine: seeded random commands plus directed corner cases,
// checked against a table model and a hash function written in the bench.
module hht_engine_tb;

    localparam int IDX   = 9;
    localparam int NSLOT = 1 << IDX;
    localparam int NWORD = 2 * NSLOT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_handle = '0;
    logic [4:0]  cmd_chan = '0;
    logic [15:0] cmd_inst = '0;
    logic [1:0]  cmd_engine = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_ctx;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] m_h [NSLOT];
    logic [31:0] m_c [NSLOT];
    logic [31:0] pool [24];

    always #10 clk = ~clk;

    hht_engine #(.IDX_W(IDX)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_handle(cmd_handle), .cmd_chan(cmd_chan), .cmd_inst(cmd_inst),
        .cmd_engine(cmd_engine),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_ctx(rsp_ctx)
    );

    function automatic logic [IDX-1:0] f_home(logic [31:0] h, logic [4:0] ch);
        logic [IDX-1:0] acc = '0;
        logic [31:0] v = h;
        logic [31:0] cw;
        for (int i = 0; i < 32; i += IDX) begin
            acc = acc ^ v[IDX-1:0];
            v = v >> IDX;
        end
        cw = {27'd0, ch} << (IDX - 4);
        return acc ^ cw[IDX-1:0];
    endfunction

    function automatic logic [31:0] f_ctx(logic [15:0] inst, logic [1:0] eng, logic [4:0] ch);
        return {1'b1, 2'b00, ch, 6'd0, eng, inst};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NSLOT; i++) begin
            m_h[i] = '0;
            m_c[i] = '0;
        end
    endtask

    // Reference probing over the model table.
    task automatic model_op(input logic [1:0] op, input logic [31:0] h, input logic [4:0] ch,
                            input logic [15:0] inst, input logic [1:0] eng,
                            output logic [1:0] st, output logic [31:0] ctx, output int lat);
        int s = int'(f_home(h, ch));
        for (int k = 1; k <= NSLOT; k++) begin
            if (op == 2'd0) begin
                if (!m_c[s][31]) begin
                    m_h[s] = h;
                    m_c[s] = f_ctx(inst, eng, ch);
                    st = 2'd0; ctx = m_c[s]; lat = 3 * k + 1;
                    return;
                end
            end else if (m_c[s][31] && m_h[s] == h) begin
                st = 2'd0; ctx = m_c[s];
                if (op == 2'd2) begin
                    m_h[s] = '0; m_c[s] = '0; lat = 3 * k + 1;
                end else begin
                    lat = 3 * k;
                end
                return;
            end
            s = (s + 1) % NSLOT;
        end
        st = (op == 2'd0) ? 2'd1 : 2'd2;
        ctx = '0;
        lat = 3 * NSLOT;
    endtask

    // Drive one command, wait for its response, compare with the model.
    task automatic run(input logic [1:0] op, input logic [31:0] h, input logic [4:0] ch,
                       input logic [15:0] inst, input logic [1:0] eng, input string req);
        logic [1:0] est;
        logic [31:0] ectx;
        int elat;
        int lat = 0;
        model_op(op, h, ch, inst, eng, est, ectx, elat);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = op; cmd_handle = h; cmd_chan = ch; cmd_inst = inst; cmd_engine = eng;
        cmd_valid = 1'b1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        chk(!cmd_ready, "R9", "ready low after accept", {31'd0, cmd_ready}, 32'd0);
        do begin
            @(posedge clk);
            #1 lat++;
        end while (!rsp_valid && lat < 4000);
        chk(rsp_status == est, req, "status", {30'd0, rsp_status}, {30'd0, est});
        chk(rsp_ctx == ectx, req, "context", rsp_ctx, ectx);
        chk(lat == elat, "R10", "latency", lat, elat);
        @(posedge clk);
        #1 chk(!rsp_valid, "R9", "single-cycle response", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic do_reset();
        int cnt = 0;
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(!rsp_valid, "R1", "no response in reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        model_clear();
        do begin
            @(posedge clk);
            #1 cnt++;
            if (cnt == 5) chk(!cmd_ready, "R1", "busy while clearing", {31'd0, cmd_ready}, 32'd0);
        end while (!cmd_ready && cnt < 5000);
        chk(cnt == NWORD, "R1", "clear length", cnt, NWORD);
    endtask

    initial begin
        logic [31:0] a;
        void'($urandom(32'h1bad5eed));
        for (int i = 0; i < 24; i++) pool[i] = $urandom();
        do_reset();

        // Directed: home slot, context packing, collisions, wrap.
        a = 32'h0001_2345;
        run(2'd0, a, 5'd3, 16'hBEEF, 2'd1, "R3");
        run(2'd1, a, 5'd3, 16'h0, 2'd0, "R2");
        run(2'd0, a ^ 32'h201, 5'd3, 16'h1111, 2'd2, "R4");
        run(2'd0, a ^ 32'h402, 5'd3, 16'h2222, 2'd3, "R4");
        run(2'd2, a ^ 32'h201, 5'd3, 16'h0, 2'd0, "R7");
        run(2'd3, a ^ 32'h402, 5'd3, 16'h0, 2'd0, "R11");
        run(2'd1, a ^ 32'h201, 5'd3, 16'h0, 2'd0, "R8");
        run(2'd0, a ^ 32'h603, 5'd3, 16'h3333, 2'd0, "R7");
        run(2'd1, a, 5'd9, 16'h0, 2'd0, "R6");
        run(2'd1, a ^ 32'h8000_0000, 5'd3, 16'h0, 2'd0, "R6");
        run(2'd0, 32'h1FF, 5'd0, 16'h0A0A, 2'd1, "R2");
        run(2'd0, 32'h3FE, 5'd0, 16'h0B0B, 2'd2, "R4");
        run(2'd1, 32'h3FE, 5'd0, 16'h0, 2'd0, "R4");

        // Seeded random mix over a small handle pool.
        for (int n = 0; n < 100; n++) begin
            int r = int'($urandom_range(99));
            logic [1:0] op = (r < 40) ? 2'd0 : (r < 70) ? 2'd1 : (r < 90) ? 2'd2 : 2'd3;
            run(op, pool[$urandom_range(23)], 5'($urandom_range(31)),
                16'($urandom()), 2'($urandom_range(3)), "R6");
        end

        // Reset wipes the table.
        do_reset();
        run(2'd1, a ^ 32'h402, 5'd3, 16'h0, 2'd0, "R1");

        // Fill every slot, then overflow.
        for (int i = 0; i < NSLOT; i++) run(2'd0, 32'(i), 5'd0, 16'(i), 2'd1, "R4");
        run(2'd0, 32'hCAFE_0001, 5'd7, 16'h5, 2'd1, "R5");
        run(2'd1, 32'hCAFE_0001, 5'd7, 16'h0, 2'd0, "R5");
        run(2'd1, 32'd300, 5'd0, 16'h0, 2'd0, "R6");
        run(2'd2, 32'd7, 5'd0, 16'h0, 2'd0, "R7");
        run(2'd0, 32'hCAFE_0001, 5'd7, 16'h6, 2'd2, "R7");
        run(2'd2, 32'hDEAD_0000, 5'd1, 16'h0, 2'd0, "R8");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule